// File: doc/BRIEF.md
# Asynchronous Serial Port with Flag-Protected Status

This block is a full-duplex asynchronous serial port. It has one transmit line, one receive line and a small register bus for the host. The port does not generate its own baud rate. It counts a single oversampling tick input (`baud_tick`), and sixteen ticks make one bit time. A frame is laid out as follows:

- one low start bit,
- eight data bits, least significant first,
- an optional ninth bit, which is either a parity bit or a multiprocessor address bit,
- one high stop bit.

The host sees four registers, selected by `bus_addr`:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit0 transmit enable, bit1 receive enable, bit2 parity enable, bit3 odd parity select, bit4 multiprocessor format, bit5 multiprocessor bit to send |
| 1 | transmit data | read/write | byte to send |
| 2 | status | read/write | bit0 transmit-data-empty (TDE), bit1 receive-data-full (RDF), bit2 parity error (PE), bit3 transmit-end (TE), bit4 received multiprocessor bit (MPB) |
| 3 | receive data | read only | last received byte |

Reads are combinational. Writes take effect at the next clock edge. Software must clear TDE, RDF and PE in two steps: it first reads the status register while the flag is 1, then writes 0 to that bit. This rule keeps a flag that was set after the last read from being cleared by accident. TE and MPB are read-only.

To transmit, the host writes the byte and then clears TDE. The byte moves into the shift register as soon as the transmitter is idle, and TDE returns to 1. A byte received with a bad parity bit is still stored in the receive data register. In that case PE is raised instead of RDF, and the receiver stays parked until software clears PE.

Top module: `uart_status_port`

## Requirements
- R1: After reset the status register reads TDE=1, RDF=0, PE=0, TE=1, MPB=0 (bits 0,1,2,3,4 of address 2), and `txd` is high.
- R2: With transmit enabled, TDE=0 and the transmitter idle, the transmit byte is loaded and TDE becomes 1. The line then carries a low start bit, the data bits LSB first, the ninth bit (if the format has one) and a high stop bit, each lasting 16 ticks. In parity format the ninth bit makes the total count of ones even (bit3=0) or odd (bit3=1).
- R3: A start bit is accepted only if the line is still low at its midpoint, and every later bit is sampled mid-bit. When the frame has no parity fault, the byte lands in the receive data register and RDF becomes 1.
- R4: In parity format (bit2=1, bit4=0), a frame whose data and parity bit disagree with the selected parity sets PE. The byte is still written to the receive data register, and RDF is left unchanged.
- R5: While PE=1 the receiver accepts no frame. The receive data register and RDF do not change.
- R6: Writing 0 to TDE, RDF or PE clears the flag only if the status register has been read with that flag at 1 since the flag was last set. Writing 1, or writing 0 without such a read, has no effect.
- R7: Clearing receive enable leaves PE and MPB unchanged.
- R8: TE becomes 1 while transmit enable is 0. It also becomes 1 when the stop bit of a frame finishes and TDE is 1. If TDE is 0 at that moment, TE stays 0 and the next byte follows.
- R9: A write to the transmit data register clears TE. A two-step clear of TDE also clears TE. A status write aimed at bit 3 has no effect on TE.
- R10: In multiprocessor format (bit4=1, which overrides parity enable), the ninth bit of each received frame is stored in MPB, no parity check is made, and the transmitter sends control bit5 as the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit time |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong arming bit inside a status flag is invisible until software tries a clear. The fault then shows as a flag that either survives or falls on the very next write, so each clear is tested both with and without a preceding read. A shift or bit-counter slip in either direction shows on `rxd` data within one frame of about 10 to 11 bit times, as a wrong received byte, a false parity error or a wrong MPB. A wrong TE decision appears only at a stop-bit boundary, so it is probed both in back-to-back transmission and on a single frame.

// File: rtl/uart_status_pkg.sv
package uart_status_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TXD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_RXD  = 2'd3;

  // status bit positions
  localparam int ST_TDE = 0;
  localparam int ST_RDF = 1;
  localparam int ST_PE  = 2;
  localparam int ST_TE  = 3;
  localparam int ST_MPB = 4;

  // number of read-then-write-zero flags (TDE, RDF, PE)
  localparam int N_RWZ = 3;

  typedef struct packed {
    logic mp_bit;
    logic mp_en;
    logic par_odd;
    logic par_en;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_rwz_flag.sv
module uart_rwz_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  output logic q_o,
  output logic clr_o
);

  logic flag_q, flag_d;
  logic armed_q, armed_d;

  always_comb begin
    flag_d = flag_q;
    clr_o  = 1'b0;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (wr_zero_i && armed_q) begin
      flag_d = 1'b0;
      clr_o  = 1'b1;
    end
    armed_d = flag_d ? (armed_q | (rd_i & flag_q)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign q_o = flag_q;

  assert_rwz_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_zero_i && armed_q));

endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_rd,
  input  logic [N_RWZ-1:0] wr_zero,
  input  logic             tdr_wr,
  input  logic             tx_en,
  input  logic             tx_load,
  input  logic             tx_done,
  input  logic             rx_commit,
  input  logic             rx_par_bad,
  input  logic             mp_en,
  input  logic             rx_ext,
  output logic             tde,
  output logic             rdf,
  output logic             pe,
  output logic             te,
  output logic             mpb
);

  localparam logic [N_RWZ-1:0] RST_VALS = 3'b001;

  logic [N_RWZ-1:0] set_v, q_v, clr_v;
  logic te_q, te_d;
  logic mpb_q, mpb_d;

  assign set_v[ST_TDE] = tx_load;
  assign set_v[ST_RDF] = rx_commit & ~rx_par_bad;
  assign set_v[ST_PE]  = rx_commit &  rx_par_bad;

  for (genvar g = 0; g < N_RWZ; g++) begin : g_flag
    uart_rwz_flag #(.RST_VAL(RST_VALS[g])) flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_v[g]),
      .rd_i      (stat_rd),
      .wr_zero_i (wr_zero[g]),
      .q_o       (q_v[g]),
      .clr_o     (clr_v[g])
    );
  end

  always_comb begin
    te_d = te_q;
    if (!tx_en || (tx_done && q_v[ST_TDE])) begin
      te_d = 1'b1;
    end else if (tdr_wr || clr_v[ST_TDE]) begin
      te_d = 1'b0;
    end
    mpb_d = (rx_commit && mp_en) ? rx_ext : mpb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q  <= 1'b1;
      mpb_q <= 1'b0;
    end else begin
      te_q  <= te_d;
      mpb_q <= mpb_d;
    end
  end

  assign tde = q_v[ST_TDE];
  assign rdf = q_v[ST_RDF];
  assign pe  = q_v[ST_PE];
  assign te  = te_q;
  assign mpb = mpb_q;

  assert_te_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(te_q) |-> $past(tdr_wr || clr_v[ST_TDE]));

  assert_te_txoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> te_q);

  assert_mpb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_commit && mp_en) |=> $stable(mpb_q));

  assert_pe_no_rdf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_commit && rx_par_bad) |=> pe && (rdf == $past(rdf)));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              has_ext,
  input  logic              ext,
  output logic              txd,
  output logic              busy,
  output logic              done
);

  localparam int CW = $clog2(OVS);
  localparam int FW = DATA_W + 3;
  localparam int IW = $clog2(FW + 1);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          xt_q, xt_d;
  logic          txd_q, txd_d;
  logic [IW-1:0] last_idx;
  logic          bit_end;

  assign last_idx = xt_q ? IW'(FW - 1) : IW'(FW - 2);
  assign bit_end  = busy_q && tick && (cnt_q == CW'(OVS - 1));
  assign done     = enable && bit_end && (idx_q == last_idx);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    xt_d   = xt_q;
    if (!enable) begin
      busy_d = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      idx_d  = '0;
      xt_d   = has_ext;
      sh_d   = has_ext ? {1'b1, ext, data, 1'b0} : {2'b11, data, 1'b0};
    end else if (busy_q && tick) begin
      if (bit_end) begin
        cnt_d = '0;
        sh_d  = {1'b1, sh_q[FW-1:1]};
        if (idx_q == last_idx) busy_d = 1'b0;
        else                   idx_d  = idx_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    txd_d = busy_d ? sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      xt_q   <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      xt_q   <= xt_d;
      txd_q  <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_q);

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_status_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              has_ext,
  input  logic              rxd,
  output logic              commit,
  output logic [DATA_W-1:0] data,
  output logic              ext
);

  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DATA_W + 1);

  logic [1:0]      sync_q;
  logic            rx_s;
  rx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [DATA_W:0] sh_q, sh_d;
  logic [IW-1:0]   last_idx;

  assign rx_s     = sync_q[1];
  assign last_idx = has_ext ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign commit   = enable && (st_q == RX_STOP) && tick && (cnt_q == CW'(OVS - 1));
  assign data     = has_ext ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
  assign ext      = sh_q[DATA_W];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    if (!enable) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx_s) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[DATA_W:1]};
            if (idx_q == last_idx) st_d  = RX_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            st_d  = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assert_rx_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == RX_IDLE) && !commit);

endmodule

// File: rtl/uart_status_port.sv
module uart_status_port
  import uart_status_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  input  logic              rxd
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic [1:0]       rst_pipe_q;
  logic             rst_i_n;
  ctrl_t            ctrl_q, ctrl_d;
  logic [DATA_W-1:0] tdr_q, tdr_d;
  logic [DATA_W-1:0] rdr_q, rdr_d;
  logic             ctrl_wr, tdr_wr, stat_wr, stat_rd;
  logic [N_RWZ-1:0] wr_zero;
  logic             has_ext, tx_ext;
  logic             tx_load, tx_busy, tx_done;
  logic             rx_commit, rx_ext, rx_par_bad, rx_enable;
  logic [DATA_W-1:0] rx_data;
  logic             tde, rdf, pe, te, mpb;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  // bus decode
  assign ctrl_wr = bus_sel &  bus_wr & (bus_addr == ADDR_CTRL);
  assign tdr_wr  = bus_sel &  bus_wr & (bus_addr == ADDR_TXD);
  assign stat_wr = bus_sel &  bus_wr & (bus_addr == ADDR_STAT);
  assign stat_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_STAT);

  assign wr_zero[ST_TDE] = stat_wr & ~bus_wdata[ST_TDE];
  assign wr_zero[ST_RDF] = stat_wr & ~bus_wdata[ST_RDF];
  assign wr_zero[ST_PE]  = stat_wr & ~bus_wdata[ST_PE];

  // frame format
  assign has_ext    = ctrl_q.mp_en | ctrl_q.par_en;
  assign tx_ext     = ctrl_q.mp_en ? ctrl_q.mp_bit : (^tdr_q ^ ctrl_q.par_odd);
  assign tx_load    = ctrl_q.tx_en & ~tx_busy & ~tde;
  assign rx_enable  = ctrl_q.rx_en & ~pe;
  assign rx_par_bad = ctrl_q.par_en & ~ctrl_q.mp_en &
                      ((^rx_data ^ rx_ext) != ctrl_q.par_odd);

  always_comb begin
    ctrl_d = ctrl_wr   ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    tdr_d  = tdr_wr    ? bus_wdata : tdr_q;
    rdr_d  = rx_commit ? rx_data   : rdr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      tdr_q  <= '0;
      rdr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tdr_q  <= tdr_d;
      rdr_q  <= rdr_d;
    end
  end

  uart_tx_shift #(.OVS(OVS), .DATA_W(DATA_W)) tx_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick    (baud_tick),
    .enable  (ctrl_q.tx_en),
    .load    (tx_load),
    .data    (tdr_q),
    .has_ext (has_ext),
    .ext     (tx_ext),
    .txd     (txd),
    .busy    (tx_busy),
    .done    (tx_done)
  );

  uart_rx_shift #(.OVS(OVS), .DATA_W(DATA_W)) rx_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick    (baud_tick),
    .enable  (rx_enable),
    .has_ext (has_ext),
    .rxd     (rxd),
    .commit  (rx_commit),
    .data    (rx_data),
    .ext     (rx_ext)
  );

  uart_status_flags flags_i (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .stat_rd    (stat_rd),
    .wr_zero    (wr_zero),
    .tdr_wr     (tdr_wr),
    .tx_en      (ctrl_q.tx_en),
    .tx_load    (tx_load),
    .tx_done    (tx_done),
    .rx_commit  (rx_commit),
    .rx_par_bad (rx_par_bad),
    .mp_en      (ctrl_q.mp_en),
    .rx_ext     (rx_ext),
    .tde        (tde),
    .rdf        (rdf),
    .pe         (pe),
    .te         (te),
    .mpb        (mpb)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      ADDR_TXD:  bus_rdata = tdr_q;
      ADDR_STAT: begin
        bus_rdata[ST_TDE] = tde;
        bus_rdata[ST_RDF] = rdf;
        bus_rdata[ST_PE]  = pe;
        bus_rdata[ST_TE]  = te;
        bus_rdata[ST_MPB] = mpb;
      end
      default:   bus_rdata = rdr_q;
    endcase
  end

  assert_pe_blocks_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    pe |-> !rx_commit);

  assert_rdr_capture_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    rx_commit |=> rdr_q == $past(rx_data));

  assert_rdf_set_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_commit && !rx_par_bad) |=> rdf);

endmodule

// File: tb/uart_status_port_tb_top.sv
module uart_status_port_tb_top;

  localparam int BT = 32; // clocks per bit: 16 ticks, one tick every 2 clocks

  logic       clk, rst_n, tick;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       txd, rxd, rx_drv, loop_en;
  int         n_chk, n_fail;
  logic [7:0] st, rv;

  assign rxd = loop_en ? txd : rx_drv;

  uart_status_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .txd       (txd),
    .rxd       (rxd)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    return logic'(ones % 2) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // read status (arming set flags), then write zero to the masked bits
  task automatic clear_flags(input logic [7:0] mask);
    logic [7:0] tmp;
    bus_read(2'd2, tmp);
    bus_write(2'd2, 8'hFF ^ mask);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has_ext, input bit ext);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = d[i];
      repeat (BT) @(negedge clk);
    end
    if (has_ext) begin
      rx_drv = ext;
      repeat (BT) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (BT + 24) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_drv = 1'b1; loop_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd2, st);
    chk("R1 tde", st[0], 1); chk("R1 rdf", st[1], 0); chk("R1 pe", st[2], 0);
    chk("R1 te", st[3], 1);  chk("R1 mpb", st[4], 0); chk("R1 txd", txd, 1);

    // R2 transmit waveform, odd parity, byte B4
    bus_write(2'd0, 8'h0D);
    bus_write(2'd1, 8'hB4);
    bus_read(2'd2, st);
    chk("R9 te cleared by data write", st[3], 0);
    bus_write(2'd2, 8'hFE);
    begin
      int lim = 0;
      while (txd !== 1'b0 && lim < 200) begin @(negedge clk); lim++; end
    end
    repeat (16) @(negedge clk);
    chk("R2 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BT) @(negedge clk);
      chk("R2 data bit", txd, (8'hB4 >> i) & 1);
    end
    repeat (BT) @(negedge clk);
    chk("R2 parity bit", txd, par_bit(8'hB4, 1'b1));
    repeat (BT) @(negedge clk);
    chk("R2 stop bit", txd, 1);
    repeat (40) @(negedge clk);
    bus_read(2'd2, st);
    chk("R8 te after last bit", st[3], 1);
    chk("R2 tde after load", st[0], 1);

    // R3/R4 loopback sweep over formats none/even/odd
    loop_en = 1'b1;
    for (int m = 0; m < 3; m++) begin
      bus_write(2'd0, 8'h03 | (m > 0 ? 8'h04 : 8'h00) | (m == 2 ? 8'h08 : 8'h00));
      for (int k = 0; k < 10; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 9) ? 8'hFF : 8'((k * 53 + m * 29) & 255);
        bus_write(2'd1, d);
        clear_flags(8'h01);
        repeat (430) @(negedge clk);
        bus_read(2'd2, st);
        chk("R3 rdf after loopback", st[1], 1);
        chk("R4 no parity error", st[2], 0);
        bus_read(2'd3, rv);
        chk("R3 received byte", rv, d);
        bus_write(2'd2, 8'hFD);
      end
    end
    loop_en = 1'b0;

    // R4/R5/R6/R7 parity error, even mode
    bus_write(2'd0, 8'h06);
    send_frame(8'h5A, 1, ~par_bit(8'h5A, 1'b0));
    bus_write(2'd2, 8'hFB);               // write zero without read
    bus_read(2'd2, st);
    chk("R6 pe survives unarmed write", st[2], 1);
    chk("R4 rdf not set on parity error", st[1], 0);
    bus_read(2'd3, rv);
    chk("R4 byte stored on parity error", rv, 8'h5A);
    send_frame(8'h33, 1, par_bit(8'h33, 1'b0));
    bus_read(2'd3, rv);
    chk("R5 rdr unchanged while pe", rv, 8'h5A);
    bus_read(2'd2, st);
    chk("R5 rdf unchanged while pe", st[1], 0);
    bus_write(2'd0, 8'h04);
    bus_read(2'd2, st);
    chk("R7 pe kept after rx disable", st[2], 1);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, st);
    chk("R6 write one no effect", st[2], 1);
    bus_write(2'd2, 8'hFB);
    bus_read(2'd2, st);
    chk("R6 pe cleared after read", st[2], 0);
    bus_write(2'd0, 8'h06);
    send_frame(8'h33, 1, par_bit(8'h33, 1'b0));
    bus_write(2'd2, 8'hFD);               // unarmed write to rdf
    bus_read(2'd2, st);
    chk("R6 rdf survives unarmed write", st[1], 1);
    bus_read(2'd3, rv);
    chk("R3 rdr after recovery", rv, 8'h33);
    bus_write(2'd2, 8'hFD);
    bus_read(2'd2, st);
    chk("R6 rdf cleared after read", st[1], 0);

    // R4 odd mode error and good frame
    bus_write(2'd0, 8'h0E);
    send_frame(8'h01, 1, ~par_bit(8'h01, 1'b1));
    bus_read(2'd2, st);
    chk("R4 odd parity error", st[2], 1);
    bus_write(2'd2, 8'hFB);
    send_frame(8'hC3, 1, par_bit(8'hC3, 1'b1));
    bus_read(2'd2, st);
    chk("R4 odd parity good", {st[2], st[1]}, 2'b01);
    bus_write(2'd2, 8'hFD);

    // R10 multiprocessor format overrides parity
    bus_write(2'd0, 8'h16);
    send_frame(8'h81, 1, 1);
    bus_read(2'd2, st);
    chk("R10 mpb one", st[4], 1);
    chk("R10 no parity check", st[2], 0);
    chk("R10 rdf set", st[1], 1);
    bus_write(2'd2, 8'hFD);
    send_frame(8'h7E, 1, 0);
    bus_read(2'd2, st);
    chk("R10 mpb zero", st[4], 0);
    bus_write(2'd2, 8'hFD);
    send_frame(8'h55, 1, 1);
    bus_write(2'd0, 8'h14);
    bus_read(2'd2, st);
    chk("R7 mpb kept after rx disable", st[4], 1);
    bus_write(2'd2, 8'hFD);
    loop_en = 1'b1;
    bus_write(2'd0, 8'h13);
    bus_write(2'd1, 8'h42);
    clear_flags(8'h01);
    repeat (430) @(negedge clk);
    bus_read(2'd2, st);
    chk("R10 transmitted mp bit zero", st[4], 0);
    bus_read(2'd3, rv);
    chk("R10 mp frame data", rv, 8'h42);
    clear_flags(8'h02);
    loop_en = 1'b0;

    // R8/R9 back-to-back transmission
    bus_write(2'd0, 8'h01);
    bus_write(2'd1, 8'h11);
    clear_flags(8'h01);
    repeat (10) @(negedge clk);
    bus_write(2'd1, 8'h22);
    clear_flags(8'h01);
    repeat (352) @(negedge clk);
    bus_read(2'd2, st);
    chk("R8 te stays low back-to-back", st[3], 0);
    chk("R2 second byte loaded", st[0], 1);
    repeat (340) @(negedge clk);
    bus_read(2'd2, st);
    chk("R8 te after final frame", st[3], 1);
    bus_write(2'd2, 8'hF7);
    bus_read(2'd2, st);
    chk("R9 te ignores status write", st[3], 1);
    clear_flags(8'h01);
    repeat (4) @(negedge clk);
    bus_read(2'd2, st);
    chk("R9 te cleared by tde clear", st[3], 0);
    repeat (360) @(negedge clk);
    bus_write(2'd1, 8'h99);
    bus_read(2'd2, st);
    chk("R9 te cleared by write while tde", st[3], 0);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, st);
    chk("R8 te set by tx disable", st[3], 1);

    finish_run();
  end

endmodule